// File: doc/BRIEF.md
# Fiber Receive Link Qualifier

This block decides whether a fiber receive link can be trusted. It watches two things: the sliced receive data line and a flag from an analog comparator. The flag says the optical signal energy is above threshold. The link counts as good only while the flag is set and the receive line keeps toggling, with no gap longer than a programmable number of clock cycles. While the link is not good, the block stays in a dark (low-light) state. In that state it withholds the enables for the transmit data path, the receive path and the loopback path. The transmitter's idle signalling is generated elsewhere and keeps running.

Loss of the link is declared quickly, within a few cycles of the gap limit or of the energy flag dropping. Recovery is slow and deliberate. The link must stay good for a long qualification interval. After that, the block waits until both the transmit-active and receive-active inputs are low, and only then re-enables the paths. If the link drops during the qualification interval, the interval starts again from zero. A bypass input holds the link in pass for receiver sensitivity testing. The status LED output is active low and is not stretched.

Top module: `fiber_link_monitor`

## Requirements
- R1: The link is good only while the energy flag is high and the receive line has toggled within the last GAP_LIMIT cycles. If the energy flag drops while in pass, link_pass falls within 3 clock cycles.
- R2: If the receive line shows no edge for GAP_LIMIT cycles, the link is lost and link_pass falls within GAP_LIMIT+4 cycles of the last edge. Toggling at intervals well below GAP_LIMIT keeps link_pass high. Toggling at intervals above GAP_LIMIT never qualifies the link.
- R3: tx_data_en, rx_en and loop_en are all 1 in pass and all 0 in the dark state.
- R4: After the link becomes good, link_pass stays low for at least QUAL_CYCLES clock cycles.
- R5: When the qualification interval ends, link_pass rises only in a cycle that follows one where tx_active and rx_active were both 0. Until then the block keeps waiting.
- R6: After reset, link_pass = 0, link_led_n = 1, and all three path enables are 0.
- R7: If the link stops being good during the qualification interval, the interval restarts from zero once the link is good again.
- R8: link_led_n is the inverse of link_pass in every cycle, with no stretching.
- R9: While bypass = 1, link_pass = 1 and all path enables are 1, whatever the line and energy inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Sliced receive data line (asynchronous) |
| energy_ok | input | 1 | Optical energy above threshold (asynchronous) |
| bypass | input | 1 | Force link pass for sensitivity testing |
| tx_active | input | 1 | Transmit path currently carrying data |
| rx_active | input | 1 | Receive path currently carrying data |
| link_pass | output | 1 | Link qualified and paths enabled |
| link_led_n | output | 1 | Active-low link status LED |
| tx_data_en | output | 1 | Transmit data path enable |
| rx_en | output | 1 | Receive path enable |
| loop_en | output | 1 | Loopback path enable |

## Verification
Some properties are checked by the assertions on every cycle:
- a rise of link_pass always follows a cycle in which both activity inputs were quiet;
- a rise of link_pass always comes after at least QUAL_CYCLES cycles of energy;
- link_pass is low three cycles after the energy flag was low;
- link_pass is low once the line has been still for longer than the gap limit plus the synchronizer lag.

The bench scenarios show the rest:
- the restart of qualification after a dropout;
- a link that never qualifies because its transitions are too slow;
- the bypass override;
- the exact state of the outputs after reset.

// File: rtl/fiber_link_monitor.sv
module fiber_link_monitor #(
  parameter int GAP_LIMIT   = 60,
  parameter int QUAL_CYCLES = 10_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_line,
  input  logic energy_ok,
  input  logic bypass,
  input  logic tx_active,
  input  logic rx_active,
  output logic link_pass,
  output logic link_led_n,
  output logic tx_data_en,
  output logic rx_en,
  output logic loop_en
);
  localparam int GW = $clog2(GAP_LIMIT + 1);
  localparam int QW = $clog2(QUAL_CYCLES + 1);
  localparam logic [GW-1:0] GAP_MAX  = GW'(GAP_LIMIT);
  localparam logic [QW-1:0] QUAL_END = QW'(QUAL_CYCLES - 1);

  typedef enum logic [1:0] {ST_DARK, ST_QUAL, ST_QUIET, ST_PASS} state_t;

  state_t          state, state_nx;
  logic [2:0]      rx_pipe;
  logic [1:0]      en_pipe;
  logic [GW-1:0]   gap_cnt;
  logic [QW-1:0]   qual_cnt;
  logic            rx_edge, signal_good;

  assign rx_edge     = rx_pipe[2] ^ rx_pipe[1];
  assign signal_good = en_pipe[1] && (gap_cnt != GAP_MAX);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_pipe <= '0;
      en_pipe <= '0;
    end else begin
      rx_pipe <= {rx_pipe[1:0], rx_line};
      en_pipe <= {en_pipe[0], energy_ok};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)               gap_cnt <= GAP_MAX;
    else if (rx_edge)         gap_cnt <= '0;
    else if (gap_cnt != GAP_MAX) gap_cnt <= gap_cnt + 1'b1;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_DARK:  if (signal_good) state_nx = ST_QUAL;
      ST_QUAL:  if (!signal_good) state_nx = ST_DARK;
                else if (qual_cnt == QUAL_END) state_nx = ST_QUIET;
      ST_QUIET: if (!signal_good) state_nx = ST_DARK;
                else if (!tx_active && !rx_active) state_nx = ST_PASS;
      ST_PASS:  if (!signal_good) state_nx = ST_DARK;
      default:  state_nx = ST_DARK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state    <= ST_DARK;
      qual_cnt <= '0;
    end else begin
      state    <= state_nx;
      qual_cnt <= (state == ST_QUAL && state_nx == ST_QUAL) ? qual_cnt + 1'b1 : '0;
    end

  assign link_pass  = bypass || (state == ST_PASS);
  assign link_led_n = ~link_pass;
  assign tx_data_en = link_pass;
  assign rx_en      = link_pass;
  assign loop_en    = link_pass;
endmodule

module fiber_link_monitor_chk #(
  parameter int GAP_LIMIT   = 60,
  parameter int QUAL_CYCLES = 10_000_000
) (
  input logic clk,
  input logic rst_n,
  input logic rx_line,
  input logic energy_ok,
  input logic bypass,
  input logic tx_active,
  input logic rx_active,
  input logic link_pass
);
  localparam int GAP_SAT = GAP_LIMIT + 4;
  localparam int CW = $clog2(GAP_SAT + 1);
  localparam int QW = $clog2(QUAL_CYCLES + 1);

  logic [CW-1:0] still_cnt;
  logic [QW-1:0] energy_run;
  logic          rx_last;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      still_cnt  <= '0;
      energy_run <= '0;
      rx_last    <= 1'b0;
    end else begin
      rx_last <= rx_line;
      if (rx_line != rx_last) still_cnt <= '0;
      else if (still_cnt != CW'(GAP_SAT)) still_cnt <= still_cnt + 1'b1;
      if (!energy_ok) energy_run <= '0;
      else if (energy_run != QW'(QUAL_CYCLES)) energy_run <= energy_run + 1'b1;
    end

  a_r5_quiet_before_pass: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_pass) && !bypass |-> $past(!tx_active && !rx_active));

  a_r4_qual_elapsed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_pass) && !bypass |-> energy_run == QW'(QUAL_CYCLES));

  a_r1_energy_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!energy_ok, 3) && !bypass |-> !link_pass);

  a_r2_gap_loss: assert property (@(posedge clk) disable iff (!rst_n)
    still_cnt == CW'(GAP_SAT) && !bypass |-> !link_pass);
endmodule

bind fiber_link_monitor fiber_link_monitor_chk #(
  .GAP_LIMIT(GAP_LIMIT), .QUAL_CYCLES(QUAL_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .energy_ok(energy_ok),
  .bypass(bypass), .tx_active(tx_active), .rx_active(rx_active),
  .link_pass(link_pass)
);

// File: tb/tb_fiber_link_monitor.sv
module tb_fiber_link_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int GAP = 16;
  localparam int Q   = 200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_line = 1'b0, energy_ok = 1'b0, bypass = 1'b0;
  logic tx_active = 1'b0, rx_active = 1'b0;
  logic link_pass, link_led_n, tx_data_en, rx_en, loop_en;
  int checks = 0, errors = 0;
  logic tog_on = 1'b0;
  int   tog_half = 2;
  bit   done = 1'b0;

  fiber_link_monitor #(.GAP_LIMIT(GAP), .QUAL_CYCLES(Q)) dut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .energy_ok(energy_ok),
    .bypass(bypass), .tx_active(tx_active), .rx_active(rx_active),
    .link_pass(link_pass), .link_led_n(link_led_n), .tx_data_en(tx_data_en),
    .rx_en(rx_en), .loop_en(loop_en));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin : toggler
    int phase = 0;
    forever begin
      @(posedge clk);
      #2;
      if (tog_on) begin
        if (phase >= tog_half - 1) begin rx_line = ~rx_line; phase = 0; end
        else phase++;
      end else phase = 0;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_outputs(input string tag, input bit pass);
    check(link_pass == pass, tag, link_pass, pass);
    check(link_led_n == !pass, {tag, " R8 led"}, link_led_n, !pass);
    check({tx_data_en, rx_en, loop_en} == {3{pass}}, {tag, " R3 enables"},
          {tx_data_en, rx_en, loop_en}, {3{pass}});
  endtask

  task automatic go_dark();
    energy_ok = 1'b0;
    wait_cyc(4);
  endtask

  task automatic t_reset();
    wait_cyc(1);
    check_outputs("R6 reset state", 1'b0);
  endtask

  task automatic t_qualify();
    tog_half = 2; tog_on = 1'b1; energy_ok = 1'b1;
    wait_cyc(Q);
    check(link_pass == 1'b0, "R4 still qualifying", link_pass, 0);
    wait_cyc(12);
    check_outputs("R4 qualified", 1'b1);
  endtask

  task automatic t_gap_loss();
    wait_cyc(GAP * 3);
    check(link_pass == 1'b1, "R2 fast toggling holds pass", link_pass, 1);
    tog_on = 1'b0;
    wait_cyc(GAP - 2);
    check(link_pass == 1'b1, "R2 gap below limit", link_pass, 1);
    wait_cyc(8);
    check_outputs("R2 gap loss", 1'b0);
    tog_on = 1'b1;
  endtask

  task automatic t_energy_loss();
    wait_cyc(Q + 12);
    check(link_pass == 1'b1, "R1 requalified", link_pass, 1);
    energy_ok = 1'b0;
    wait_cyc(3);
    check_outputs("R1 energy loss", 1'b0);
  endtask

  task automatic t_restart();
    energy_ok = 1'b1;
    wait_cyc(Q / 2);
    energy_ok = 1'b0;
    wait_cyc(4);
    energy_ok = 1'b1;
    wait_cyc(Q);
    check(link_pass == 1'b0, "R7 qualification restarted", link_pass, 0);
    wait_cyc(12);
    check(link_pass == 1'b1, "R7 pass after full interval", link_pass, 1);
  endtask

  task automatic t_quiet();
    go_dark();
    tx_active = 1'b1;
    energy_ok = 1'b1;
    wait_cyc(Q + 12);
    check_outputs("R5 held by tx_active", 1'b0);
    tx_active = 1'b0; rx_active = 1'b1;
    wait_cyc(5);
    check(link_pass == 1'b0, "R5 held by rx_active", link_pass, 0);
    rx_active = 1'b0;
    wait_cyc(2);
    check_outputs("R5 pass once quiet", 1'b1);
  endtask

  task automatic t_slow();
    go_dark();
    tog_half = GAP + 4;
    energy_ok = 1'b1;
    wait_cyc(Q + 40);
    check(link_pass == 1'b0, "R2 slow toggling never qualifies", link_pass, 0);
    tog_half = 2;
  endtask

  task automatic t_bypass();
    go_dark();
    tog_on = 1'b0;
    bypass = 1'b1;
    wait_cyc(1);
    check_outputs("R9 bypass forces pass", 1'b1);
    wait_cyc(GAP * 2);
    check(link_pass == 1'b1, "R9 bypass holds without line", link_pass, 1);
    bypass = 1'b0;
    wait_cyc(1);
    check_outputs("R9 bypass release", 1'b0);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    t_reset();
    t_qualify();
    t_gap_loss();
    t_energy_loss();
    t_restart();
    t_quiet();
    t_slow();
    t_bypass();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100_000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule